// File: doc/BRIEF.md
# Serial-bus memory erase sequencer

This block is the slave side of a small serial memory on a three-wire bus with a select line, a serial clock and a serial data input, plus one status output. It shifts in a command frame: a start bit, a two-bit opcode and an address. It then either erases one word of its internal register file or erases the whole file to all ones. Once the last address bit has been sampled, each erase runs as a self-timed internal cycle that counts system clocks. No further serial clock edges are needed.

While an erase is pending, the host polls for completion. It holds select low for a minimum number of system cycles and then raises it again. The status line then leaves high impedance and reports busy or ready until select falls. The serial inputs are asynchronous and are synchronised into the system clock domain. A read port on the register file lets the surrounding logic observe the stored words. Erasing is allowed only while an enable input is high.

Top module: `mw_erase_seq`

## Requirements
- R1: After reset, word i of the register file holds i modulo 2^DATA_W, and do_oe_o is 0.
- R2: A frame is sampled on rising sclk_i edges while cs_i is high. It consists of a 1 start bit, opcode bit 1, opcode bit 0, and then ADDR_W address bits MSB first. The erase cycle starts from the edge that samples the last address bit and completes with sclk_i held still.
- R3: Opcode 11 sets every bit of the addressed word to 1 when the cycle of ERASE_CYC system cycles ends. All other words keep their contents.
- R4: Opcode 00 with the two top address bits equal to 10 sets every word to all ones after a cycle of ERAL_CYC system cycles, which is longer than ERASE_CYC. Opcode 00 with any other top bits, and opcodes 01 and 10, change nothing.
- R5: do_oe_o becomes 1 only after an erase has been started and cs_i has been low for at least CSL_CYC system cycles and then risen. It stays 1 while cs_i is high and returns to 0 after cs_i falls. A shorter low interval opens no window.
- R6: While do_oe_o is 1, do_o is 0 as long as the erase is running and 1 once it has finished.
- R7: With erase_en_i low, a complete erase frame is discarded: the array is unchanged and no status window opens.
- R8: A frame that completes while an erase is running is ignored. Its target word is not changed.
- R9: Lowering cs_i in mid-frame discards the partial frame. The next frame is decoded from a fresh start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Serial select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous, sampled |
| di_i | input | 1 | Serial data in, asynchronous |
| erase_en_i | input | 1 | Erase permission |
| rd_addr_i | input | ADDR_W | Register file read address |
| rd_data_o | output | DATA_W | Register file read data |
| do_o | output | 1 | Status value (1 ready, 0 busy) |
| do_oe_o | output | 1 | Status output enable; 0 means high impedance |

## Verification
The bench uses ADDR_W=4 and DATA_W=8, so a full array erase touches all 16 words and every word can be read back. It sets CSL_CYC=5, which lets a 2-cycle select-low pulse fall short of the minimum while a 10-cycle pulse meets it. ERASE_CYC=200 is long enough to shift a second complete frame in during a running erase. ERAL_CYC=600 lets a poll placed after 300 cycles tell the two cycle lengths apart.

// File: rtl/mw_erase_pkg.sv
package mw_erase_pkg;
  typedef enum logic [1:0] {
    OPC_ALL  = 2'b00,
    OPC_WORD = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_OPC,
    RX_ADDR,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
  import mw_erase_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_rise_i,
  input  logic              di_i,
  output logic              cmd_valid_o,
  output logic [1:0]        opc_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int CNT_W = $clog2(ADDR_W + 2);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      cnt_q       <= '0;
      cmd_valid_o <= 1'b0;
      opc_o       <= '0;
      addr_o      <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (!cs_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else if (sclk_rise_i) begin
        unique case (state_q)
          RX_IDLE: if (di_i) begin
            state_q <= RX_OPC;
            cnt_q   <= '0;
          end
          RX_OPC: begin
            opc_o <= {opc_o[0], di_i};
            if (cnt_q == CNT_W'(1)) begin
              state_q <= RX_ADDR;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_ADDR: begin
            addr_o <= {addr_o[ADDR_W-2:0], di_i};
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              state_q     <= RX_HOLD;
              cmd_valid_o <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;  // frame complete, wait for CS low
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_erase_timer.sv
module mw_erase_timer #(
  parameter int ERASE_CYC = 200,
  parameter int ERAL_CYC  = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic busy_o,
  output logic done_o
);
  localparam int MAX_CYC = (ERAL_CYC > ERASE_CYC) ? ERAL_CYC : ERASE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        cnt_q  <= long_i ? CW'(ERAL_CYC - 1) : CW'(ERASE_CYC - 1);
      end else if (busy_o) begin
        if (cnt_q == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mw_status.sv
module mw_status #(
  parameter int CSL_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic busy_i,
  input  logic start_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int LW = $clog2(CSL_CYC + 1);

  logic [LW-1:0] low_q;
  logic          cs_d_q, armed_q, win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q   <= '0;
      cs_d_q  <= 1'b0;
      armed_q <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      cs_d_q <= cs_i;
      if (cs_i) low_q <= '0;
      else if (low_q < LW'(CSL_CYC)) low_q <= low_q + 1'b1;
      // armed from start until CS falls after ready was shown
      if (start_i) armed_q <= 1'b1;
      else if (win_q && !cs_i && !busy_i) armed_q <= 1'b0;
      if (!cs_i) win_q <= 1'b0;
      else if (!cs_d_q && low_q >= LW'(CSL_CYC) && armed_q) win_q <= 1'b1;
    end
  end

  assign do_oe_o = win_q;
  assign do_o    = ~busy_i;
endmodule

// File: rtl/mw_erase_seq.sv
module mw_erase_seq
  import mw_erase_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int SYNC_STG  = 2,
  parameter int CSL_CYC   = 5,
  parameter int ERASE_CYC = 200,
  parameter int ERAL_CYC  = 600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              di_i,
  input  logic              erase_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              do_o,
  output logic              do_oe_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic              cs_s, sclk_s, di_s, sclk_d_q;
  logic              cmd_valid, busy, done, start;
  logic              is_word, is_all, all_q;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] addr, tgt_q;
  logic [DATA_W-1:0] mem_q [WORDS];

  mw_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_i, sclk_i, di_i}),
    .q_o ({cs_s, sclk_s, di_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s;
  end

  mw_frame_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk_i, .rst_ni,
    .cs_i        (cs_s),
    .sclk_rise_i (sclk_s & ~sclk_d_q),
    .di_i        (di_s),
    .cmd_valid_o (cmd_valid),
    .opc_o       (opc),
    .addr_o      (addr)
  );

  assign is_word = (opc == OPC_WORD);
  assign is_all  = (opc == OPC_ALL) && (addr[ADDR_W-1 -: 2] == 2'b10);
  assign start   = cmd_valid && (is_word || is_all) && erase_en_i && !busy;

  mw_erase_timer #(.ERASE_CYC(ERASE_CYC), .ERAL_CYC(ERAL_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .start_i (start),
    .long_i  (is_all),
    .busy_o  (busy),
    .done_o  (done)
  );

  mw_status #(.CSL_CYC(CSL_CYC)) u_stat (
    .clk_i, .rst_ni,
    .cs_i    (cs_s),
    .busy_i  (busy),
    .start_i (start),
    .do_o,
    .do_oe_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
      all_q <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem_q[i] <= DATA_W'(i);
    end else begin
      if (start) begin
        tgt_q <= addr;
        all_q <= is_all;
      end
      if (done) begin
        if (all_q) for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        else       mem_q[tgt_q] <= '1;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/mw_erase_seq_chk.sv
module mw_erase_seq_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              erase_en_i,
  input logic              cs_s,
  input logic              busy,
  input logic              cmd_valid,
  input logic              do_oe_o,
  input logic [ADDR_W-1:0] tgt_q
);
  a_r2_start_from_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(cmd_valid));

  a_r7_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(erase_en_i));

  a_r5_oe_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !do_oe_o);

  a_r5_oe_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_oe_o && cs_s) |=> do_oe_o);

  a_r8_target_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(tgt_q));
endmodule

bind mw_erase_seq mw_erase_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .erase_en_i,
  .cs_s, .busy, .cmd_valid, .do_oe_o, .tgt_q
);

// File: tb/mw_erase_seq_tb.sv
module mw_erase_seq_tb;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0, sclk = 1'b0, di = 1'b0, en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          do_v, do_oe;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  typedef struct {
    int    kind;  // 0 word, 1 oe, 2 do
    int    addr;
    int    exp;
    string req;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  mw_erase_seq #(
    .ADDR_W(AW), .DATA_W(DW), .SYNC_STG(2),
    .CSL_CYC(5), .ERASE_CYC(200), .ERAL_CYC(600)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .erase_en_i(en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .do_o(do_v), .do_oe_o(do_oe)
  );

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        int act;
        it = sb_q[0];
        if (it.kind == 0) rd_addr = AW'(it.addr);
        #1;
        act = (it.kind == 0) ? int'(rd_data) : (it.kind == 1) ? int'(do_oe) : int'(do_v);
        n_chk++;
        if (act != it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d addr=%0d actual=%0d expected=%0d",
                   it.req, it.kind, it.addr, act, it.exp);
        end
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic expect_item(input int kind, input int addr, input int exp, input string req);
    item_t it;
    it.kind = kind; it.addr = addr; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    while (sb_q.size() > 0) @(posedge clk);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    di = b; cyc(4);
    sclk = 1'b1; cyc(4);
    sclk = 1'b0;
  endtask

  task automatic send_frame(input int opc, input int addr);
    cs = 1'b0; cyc(3);
    cs = 1'b1; cyc(2);
    send_bit(1'b1);
    send_bit(opc[1]); send_bit(opc[0]);
    for (int i = AW - 1; i >= 0; i--) send_bit(addr[i]);
    di = 1'b0;
  endtask

  task automatic poll_open(input int low);
    cs = 1'b0; cyc(low);
    cs = 1'b1; cyc(8);
  endtask

  task automatic poll_close();
    cs = 1'b0; cyc(8);
  endtask

  // watchdog
  initial begin
    cyc(200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    expect_item(1, 0, 0, "R1");
    for (int i = 0; i < 16; i++) expect_item(0, i, i, "R1");

    en = 1'b1;
    // R2/R3 word erase, R6 busy then ready
    send_frame(3, 5);
    poll_open(10);
    expect_item(1, 0, 1, "R5");
    expect_item(2, 0, 0, "R6");
    expect_item(0, 5, 5, "R3");
    cyc(250);
    expect_item(2, 0, 1, "R6");
    expect_item(0, 5, 255, "R3");
    expect_item(0, 4, 4, "R3");
    expect_item(0, 6, 6, "R3");
    poll_close();
    expect_item(1, 0, 0, "R5");

    // R7 disabled erase
    en = 1'b0;
    send_frame(3, 6);
    cyc(20);
    poll_open(10);
    expect_item(1, 0, 0, "R7");
    cyc(250);
    expect_item(0, 6, 6, "R7");
    poll_close();
    en = 1'b1;

    // R9 aborted frame then clean frame
    cs = 1'b0; cyc(3); cs = 1'b1; cyc(2);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    cs = 1'b0; cyc(4);
    send_frame(3, 8);
    poll_open(10);
    expect_item(1, 0, 1, "R9");
    cyc(250);
    expect_item(0, 8, 255, "R9");
    expect_item(0, 10, 10, "R9");
    expect_item(0, 11, 11, "R9");
    poll_close();

    // R5 short low gives no window; R8 frame during busy ignored
    send_frame(3, 2);
    cs = 1'b0; cyc(2);
    cs = 1'b1; cyc(8);
    expect_item(1, 0, 0, "R5");
    send_frame(3, 9);
    poll_open(10);
    expect_item(2, 0, 0, "R8");
    cyc(250);
    expect_item(2, 0, 1, "R6");
    poll_close();
    expect_item(0, 2, 255, "R8");
    expect_item(0, 9, 9, "R8");

    // R4 non-matching opcodes do nothing
    send_frame(0, 4'b1100);
    send_frame(1, 3);
    send_frame(2, 3);
    cyc(20);
    poll_open(10);
    expect_item(1, 0, 0, "R4");
    poll_close();
    expect_item(0, 12, 12, "R4");
    expect_item(0, 3, 3, "R4");

    // R4 whole-array erase, longer cycle, no sclk after frame (R2)
    send_frame(0, 4'b1001);
    poll_open(10);
    expect_item(2, 0, 0, "R4");
    cyc(300);
    expect_item(2, 0, 0, "R4");
    expect_item(0, 0, 0, "R4");
    cyc(400);
    expect_item(2, 0, 1, "R2");
    poll_close();
    expect_item(1, 0, 0, "R5");
    expect_item(0, 0, 255, "R4");
    expect_item(0, 7, 255, "R4");
    expect_item(0, 9, 255, "R4");
    expect_item(0, 15, 255, "R4");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule